// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block follows the power state of a processor core from four active-low power-control inputs: stop-clock, sleep, deep-sleep and reset. It moves between five states: Normal, Stop-Grant, Stop-Grant Snoop, Sleep and Deep Sleep. It drives a clock-enable output that the clock gating cells downstream use. Snoop and interrupt traffic that arrives while the core is halted moves it briefly into the snoop state. It returns to Stop-Grant once the snoop completes or the interrupt has been captured.

Interrupt requests (SMI, INIT and a parameterised number of local interrupt lines) are held in one pending bit per type, so several arrivals of the same type collapse into one. While the core is halted and anything is pending, an active-low break request asks the system to wake it. This happens even when maskable interrupts are disabled. Once the core is back in Normal, the pending requests come out as single-cycle pulses, one per clock, in a fixed priority order. Sleep assertions outside Stop-Grant are flagged, and so are snoops that arrive while the clocks are stopped. Both flags are sticky until reset.

Top module: `lowpwr_ctl`

## Requirements
- R1: Reset (rstN low) acts asynchronously from any state, including Sleep and Deep Sleep, and gives pwrState 0, clkEn 1, pbeN 1, irqOut 0, with slpErr and protoErr cleared. If stpClkN is low when reset ends, the first clock edge moves the block to Stop-Grant.
- R2: pwrState encodes Normal=0, Stop-Grant=1, Stop-Grant Snoop=2, Sleep=3, Deep Sleep=4. On a clock edge, stpClkN low in Normal enters Stop-Grant, and stpClkN high in Stop-Grant returns to Normal.
- R3: Sleep is entered only from Stop-Grant, on an edge where slpN is low. slpN low in Normal or Stop-Grant Snoop leaves the state unchanged and sets the sticky slpErr output.
- R4: A snoopReq or any irqReq bit in Stop-Grant enters Stop-Grant Snoop. A snoop keeps the block there until the edge where snoopDone is high. snoopSvc is high in that cycle. When only an interrupt caused the entry, the block returns to Stop-Grant on the next edge.
- R5: Requests are captured in Normal, Stop-Grant and Stop-Grant Snoop, with one pending bit per type. In Normal they are released as one-cycle irqOut pulses (bit 0 SMI, bit 1 INIT, bit 2 LINT0, bit 3 LINT1), lowest bit first, one per clock. The first pulse comes one cycle after Normal is reached, and each type is delivered once however many times it arrived.
- R6: pbeN is low in Stop-Grant and Stop-Grant Snoop whenever any request or a monitor event (monEvt) is pending, whatever the value of intEnable. It is high in every other case. A monitor event is cleared once the block is in Normal.
- R7: In Sleep and Deep Sleep, clkEn is low and irqReq pulses are not captured.
- R8: deep-sleep low (dpSlpN) in Sleep enters Deep Sleep, and dpSlpN high in Deep Sleep returns to Sleep. slpN high in Sleep returns to Stop-Grant.
- R9: A snoopReq in Sleep or Deep Sleep sets protoErr, which stays set until reset.
- R10: While intEnable is low, the local interrupt lines (bits 2 and up) stay pending in Normal. SMI and INIT are still released.
- R11: irqOut has at most one bit high, and only in the cycle after a cycle spent in Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| stpClkN | input | 1 | Active-low stop-clock request |
| slpN | input | 1 | Active-low sleep request |
| dpSlpN | input | 1 | Active-low deep-sleep request |
| snoopReq | input | 1 | Snoop request strobe |
| snoopDone | input | 1 | Snoop serviced strobe |
| irqReq | input | IRQ_W | Interrupt pulses: SMI, INIT, LINT0, LINT1 |
| monEvt | input | 1 | Monitor event pulse |
| intEnable | input | 1 | Maskable interrupt enable flag |
| pwrState | output | 3 | Current power state code |
| clkEn | output | 1 | Enable for the gated core clock |
| pbeN | output | 1 | Active-low pending-break request |
| irqOut | output | IRQ_W | Released interrupt pulses |
| snoopSvc | output | 1 | Snoop serviced in snoop state |
| slpErr | output | 1 | Sticky illegal-sleep flag |
| protoErr | output | 1 | Sticky snoop-while-asleep flag |

## Verification
The assertions assume that every input is synchronous to clk and that rstN is held low from time zero. They also assume that a sleep request is removed before the block is expected to leave Sleep, because an illegal sleep outside Stop-Grant is only flagged and the state stays put. The stimulus changes every input on the falling edge and drives each request as a single-cycle pulse. snoopDone is raised only after a matching snoopReq, and the clocks-stopped states see snoops only in the cases meant to trip the protocol flag.

// File: rtl/lowpwr_pkg.sv
package lowpwr_pkg;

  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    PS_NORMAL      = 3'd0,
    PS_GRANT       = 3'd1,
    PS_GRANT_SNOOP = 3'd2,
    PS_SLEEP       = 3'd3,
    PS_DEEP        = 3'd4
  } pwrState_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic latchEn;    // capture incoming requests
    logic releaseEn;  // deliver pending requests
    logic grantView;  // break request may be raised
    logic clearMon;   // drop pending monitor event
  } pwrStrobe_t;

endpackage

// File: rtl/lowpwr_fsm.sv
module lowpwr_fsm
  import lowpwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stpClkN,
  input  logic       slpN,
  input  logic       dpSlpN,
  input  logic       snoopReq,
  input  logic       snoopDone,
  input  logic       irqAny,
  output pwrState_e  state,
  output pwrStrobe_t strobe,
  output logic       clkEn,
  output logic       snoopSvc,
  output logic       slpErr,
  output logic       protoErr
);

  pwrState_e stateNext;
  logic      snoopOpen;
  logic      snoopHold;
  logic      inGrant;
  logic      asleep;

  assign inGrant   = (state == PS_GRANT) || (state == PS_GRANT_SNOOP);
  assign asleep    = (state == PS_SLEEP) || (state == PS_DEEP);
  assign snoopHold = (snoopOpen && !snoopDone) || snoopReq;

  always_comb begin
    stateNext = state;
    unique case (state)
      PS_NORMAL:      if (!stpClkN) stateNext = PS_GRANT;
      PS_GRANT: begin
        if (!slpN)                     stateNext = PS_SLEEP;
        else if (snoopReq || irqAny)   stateNext = PS_GRANT_SNOOP;
        else if (stpClkN)              stateNext = PS_NORMAL;
      end
      PS_GRANT_SNOOP: if (!snoopHold) stateNext = PS_GRANT;
      PS_SLEEP: begin
        if (!dpSlpN)    stateNext = PS_DEEP;
        else if (slpN)  stateNext = PS_GRANT;
      end
      PS_DEEP:        if (dpSlpN) stateNext = PS_SLEEP;
      default:        stateNext = PS_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= PS_NORMAL;
      snoopOpen <= 1'b0;
      slpErr    <= 1'b0;
      protoErr  <= 1'b0;
    end else begin
      state     <= stateNext;
      snoopOpen <= inGrant && ((snoopOpen && !snoopDone) || snoopReq);
      if (!slpN && (state == PS_NORMAL || state == PS_GRANT_SNOOP))
        slpErr <= 1'b1;
      if (snoopReq && asleep)
        protoErr <= 1'b1;
    end
  end

  assign strobe.latchEn   = !asleep;
  assign strobe.releaseEn = (state == PS_NORMAL);
  assign strobe.grantView = inGrant;
  assign strobe.clearMon  = (state == PS_NORMAL);

  assign clkEn    = !asleep;
  assign snoopSvc = (state == PS_GRANT_SNOOP) && snoopOpen && snoopDone;

endmodule

// File: rtl/lowpwr_irq.sv
module lowpwr_irq
  import lowpwr_pkg::*;
#(
  parameter int IRQ_W = 4,
  parameter int NMI_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwrStrobe_t       strobe,
  input  logic [IRQ_W-1:0] irqReq,
  input  logic             monEvt,
  input  logic             intEnable,
  output logic [IRQ_W-1:0] irqOut,
  output logic             pbeN
);

  logic [IRQ_W-1:0] pend;
  logic [IRQ_W-1:0] eligible;
  logic [IRQ_W-1:0] pick;
  logic             monPend;
  logic             found;

  // non-maskable types always eligible, local lines follow the enable
  always_comb begin
    for (int i = 0; i < IRQ_W; i++)
      eligible[i] = pend[i] && strobe.releaseEn && ((i < NMI_W) || intEnable);
  end

  // fixed priority: lowest index first, one per clock
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < IRQ_W; i++) begin
      if (eligible[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend    <= '0;
      irqOut  <= '0;
      monPend <= 1'b0;
    end else begin
      pend   <= (pend & ~pick) | (strobe.latchEn ? irqReq : '0);
      irqOut <= pick;
      if (strobe.clearMon)
        monPend <= 1'b0;
      else if (strobe.latchEn && monEvt)
        monPend <= 1'b1;
    end
  end

  assign pbeN = !(strobe.grantView && ((|pend) || monPend));

endmodule

// File: rtl/lowpwr_ctl.sv
module lowpwr_ctl
  import lowpwr_pkg::*;
#(
  parameter  int LINT_LINES = 2,
  localparam int NMI_W      = 2,
  localparam int IRQ_W      = NMI_W + LINT_LINES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stpClkN,
  input  logic             slpN,
  input  logic             dpSlpN,
  input  logic             snoopReq,
  input  logic             snoopDone,
  input  logic [IRQ_W-1:0] irqReq,
  input  logic             monEvt,
  input  logic             intEnable,
  output logic [2:0]       pwrState,
  output logic             clkEn,
  output logic             pbeN,
  output logic [IRQ_W-1:0] irqOut,
  output logic             snoopSvc,
  output logic             slpErr,
  output logic             protoErr
);

  pwrState_e  state;
  pwrStrobe_t strobe;

  lowpwr_fsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .stpClkN   (stpClkN),
    .slpN      (slpN),
    .dpSlpN    (dpSlpN),
    .snoopReq  (snoopReq),
    .snoopDone (snoopDone),
    .irqAny    (|irqReq),
    .state     (state),
    .strobe    (strobe),
    .clkEn     (clkEn),
    .snoopSvc  (snoopSvc),
    .slpErr    (slpErr),
    .protoErr  (protoErr)
  );

  lowpwr_irq #(.IRQ_W(IRQ_W), .NMI_W(NMI_W)) u_irq (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .irqReq    (irqReq),
    .monEvt    (monEvt),
    .intEnable (intEnable),
    .irqOut    (irqOut),
    .pbeN      (pbeN)
  );

  assign pwrState = state;

endmodule

// File: rtl/lowpwr_ctl_chk.sv
module lowpwr_ctl_chk #(
  parameter int IRQ_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             snoopReq,
  input logic [IRQ_W-1:0] irqReq,
  input logic [2:0]       pwrState,
  input logic             clkEn,
  input logic             pbeN,
  input logic [IRQ_W-1:0] irqOut,
  input logic             protoErr
);

  // R3: Sleep only follows Stop-Grant (or Sleep/Deep itself)
  p_sleep_entry_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pwrState) != 3'd1 && $past(pwrState) != 3'd3 && $past(pwrState) != 3'd4)
      |-> pwrState != 3'd3);

  // R8: Deep Sleep only follows Sleep
  p_deep_entry_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pwrState) != 3'd3 && $past(pwrState) != 3'd4) |-> pwrState != 3'd4);

  // R4: an open snoop holds the snoop state
  p_snoop_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 3'd2 && snoopReq) |=> pwrState == 3'd2);

  // R6: a masked or unmasked request raises the break request in grant states
  p_break_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pwrState == 3'd1 && (|irqReq)) && (pwrState == 3'd1 || pwrState == 3'd2))
      |-> !pbeN);

  // R7: clocks gated when asleep
  p_clk_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 3'd3 || pwrState == 3'd4) |-> !clkEn);

  // R9: protocol error is sticky
  p_proto_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(protoErr) |-> protoErr);

  // R11: single release, only after a Normal cycle
  p_one_release_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqOut));

  p_release_normal_r11: assert property (@(posedge clk) disable iff (!rstN)
    (|irqOut) |-> $past(pwrState) == 3'd0);

endmodule

bind lowpwr_ctl lowpwr_ctl_chk #(.IRQ_W(IRQ_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .snoopReq (snoopReq),
  .irqReq   (irqReq),
  .pwrState (pwrState),
  .clkEn    (clkEn),
  .pbeN     (pbeN),
  .irqOut   (irqOut),
  .protoErr (protoErr)
);

// File: tb/lowpwr_ctl_test.sv
module lowpwr_ctl_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       stpClkN, slpN, dpSlpN, snoopReq, snoopDone, monEvt, intEnable;
  logic [3:0] irqReq;
  logic [2:0] pwrState;
  logic       clkEn, pbeN, snoopSvc, slpErr, protoErr;
  logic [3:0] irqOut;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #2 clk = ~clk;

  lowpwr_ctl uut (
    .clk(clk), .rstN(rstN), .stpClkN(stpClkN), .slpN(slpN), .dpSlpN(dpSlpN),
    .snoopReq(snoopReq), .snoopDone(snoopDone), .irqReq(irqReq), .monEvt(monEvt),
    .intEnable(intEnable), .pwrState(pwrState), .clkEn(clkEn), .pbeN(pbeN),
    .irqOut(irqOut), .snoopSvc(snoopSvc), .slpErr(slpErr), .protoErr(protoErr)
  );

  // {stpClkN, slpN, dpSlpN, snoopReq, snoopDone, expected state[2:0]}
  localparam logic [7:0] VEC [9] = '{
    8'b0_1_1_0_0_001,  // R2 Normal -> Stop-Grant
    8'b0_0_1_0_0_011,  // R3 Stop-Grant -> Sleep
    8'b0_0_0_0_0_100,  // R8 Sleep -> Deep
    8'b0_0_1_0_0_011,  // R8 Deep -> Sleep
    8'b0_1_1_0_0_001,  // R8 Sleep -> Stop-Grant
    8'b0_1_1_1_0_010,  // R4 snoop -> Snoop state
    8'b0_1_1_0_0_010,  // R4 hold until done
    8'b0_1_1_0_1_001,  // R4 done -> Stop-Grant
    8'b1_1_1_0_0_000   // R2 Stop-Grant -> Normal
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end

  initial begin
    rstN = 1'b0; stpClkN = 1'b1; slpN = 1'b1; dpSlpN = 1'b1;
    snoopReq = 1'b0; snoopDone = 1'b0; monEvt = 1'b0; intEnable = 1'b0; irqReq = '0;
    repeat (2) @(negedge clk);
    chk("R1 reset state", int'(pwrState), 0);
    chk("R1 reset clkEn", int'(clkEn), 1);
    chk("R1 reset pbeN", int'(pbeN), 1);
    chk("R1 reset irqOut", int'(irqOut), 0);
    chk("R1 reset flags", int'({slpErr, protoErr}), 0);
    rstN = 1'b1;
    step();

    // table walk of the state transitions
    for (int i = 0; i < 9; i++) begin
      {stpClkN, slpN, dpSlpN, snoopReq, snoopDone} = VEC[i][7:3];
      #1;
      if (i == 7) chk("R4 snoopSvc on done", int'(snoopSvc), 1);
      step();
      chk($sformatf("R2 table row %0d state", i), int'(pwrState), int'(VEC[i][2:0]));
      chk($sformatf("R7 table row %0d clkEn", i), int'(clkEn),
          (VEC[i][2:0] >= 3'd3) ? 0 : 1);
    end
    snoopReq = 1'b0; snoopDone = 1'b0;

    // R3 illegal sleep in Normal
    slpN = 1'b0; step(); slpN = 1'b1;
    chk("R3 illegal sleep state", int'(pwrState), 0);
    chk("R3 illegal sleep flag", int'(slpErr), 1);
    rstN = 1'b0; @(negedge clk);
    chk("R1 reset clears slpErr", int'(slpErr), 0);
    rstN = 1'b1; step();

    // R6 monitor event
    stpClkN = 1'b0; step();
    chk("R6 idle grant pbeN", int'(pbeN), 1);
    monEvt = 1'b1; step(); monEvt = 1'b0;
    chk("R6 monitor state", int'(pwrState), 1);
    chk("R6 monitor pbeN", int'(pbeN), 0);
    stpClkN = 1'b1; step();
    chk("R6 pbeN high in Normal", int'(pbeN), 1);
    step();
    stpClkN = 1'b0; step();
    chk("R6 monitor cleared", int'(pbeN), 1);

    // R4 R5 R6 R10 interrupts with intEnable low
    irqReq = 4'b1111; step(); irqReq = '0;
    chk("R4 irq enters snoop state", int'(pwrState), 2);
    chk("R6 masked break request", int'(pbeN), 0);
    step();
    chk("R4 irq returns to grant", int'(pwrState), 1);
    irqReq = 4'b0001; step(); irqReq = '0;
    chk("R4 repeat irq snoop state", int'(pwrState), 2);
    step();
    chk("R4 repeat irq back", int'(pwrState), 1);
    stpClkN = 1'b1; step();
    chk("R2 wake to Normal", int'(pwrState), 0);
    chk("R5 no release on entry", int'(irqOut), 0);
    step(); chk("R5 SMI first", int'(irqOut), 1);
    step(); chk("R5 INIT second", int'(irqOut), 2);
    step(); chk("R10 LINT held while masked", int'(irqOut), 0);
    intEnable = 1'b1;
    step(); chk("R5 LINT0 third", int'(irqOut), 4);
    step(); chk("R5 LINT1 fourth", int'(irqOut), 8);
    step(); chk("R5 each type once", int'(irqOut), 0);

    // R7 R8 R9 sleep behaviour
    stpClkN = 1'b0; step();
    slpN = 1'b0; step();
    chk("R7 sleep clkEn", int'(clkEn), 0);
    irqReq = 4'b1111; snoopReq = 1'b1; step(); irqReq = '0; snoopReq = 1'b0;
    chk("R7 sleep state held", int'(pwrState), 3);
    chk("R9 snoop in sleep", int'(protoErr), 1);
    dpSlpN = 1'b0; step();
    chk("R8 enter deep", int'(pwrState), 4);
    snoopReq = 1'b1; step(); snoopReq = 1'b0;
    dpSlpN = 1'b1; step();
    chk("R8 back to sleep", int'(pwrState), 3);
    slpN = 1'b1; step();
    chk("R8 sleep to grant", int'(pwrState), 1);
    chk("R7 nothing latched asleep", int'(pbeN), 1);
    chk("R9 flag sticky", int'(protoErr), 1);

    // R1 reset from Sleep with stop-clock held
    slpN = 1'b0; step();
    rstN = 1'b0; #1;
    chk("R1 async reset state", int'(pwrState), 0);
    chk("R1 reset clkEn", int'(clkEn), 1);
    chk("R1 reset clears protoErr", int'(protoErr), 0);
    slpN = 1'b1; step();
    rstN = 1'b1; step();
    chk("R1 stays in grant", int'(pwrState), 1);
    stpClkN = 1'b1; step(); step(); step();
    chk("R7 no stale release", int'(irqOut), 0);

    finishRun();
  end

endmodule